// File: doc/BRIEF.md
# Legacy Bus-Master Grant Flush Gate

This block sits between the arbiter of a legacy expansion bus and the outbound posted-write buffer of a host bridge. The legacy bus cannot retry a transaction. A master that has started a cycle keeps the bus until the cycle ends, and it can only be stretched with wait states. If the master were granted while host writes toward the legacy bus were still buffered, its read data would queue behind those writes, and those writes would wait for a bus the master never releases. The result is a deadlock.

The gate removes that deadlock. A master request first raises a dedicated out-of-band flush request to the bridge and inhibits the bridge from accepting new legacy-bound posted writes. The grant is given only after the bridge's buffer-empty indication has been seen high for a qualifying run of clocks. When the master drops its request, the grant is removed first and the write inhibit is lifted one clock later. A build with no legacy masters sets `HAS_MASTER` to 0, and the gate then stays idle.

Top module: `master_flush_gate`

## Requirements
- R1: A synchronous active-high reset puts the gate idle, with grant, flush request and write inhibit all low on the first clock after reset.
- R2: A master request sampled while the gate is idle raises the flush request and the write inhibit on the next clock, with the grant still low.
- R3: The grant rises only after the buffer-empty input has been sampled high on `EMPTY_HOLD` consecutive clocks while the flush request is high. With the input steadily high, the grant rises `EMPTY_HOLD`+2 clocks after the request is first sampled.
- R4: While the buffer-empty input stays low, the grant stays low for as long as the request is held.
- R5: The write inhibit is high whenever the flush request or the grant is high, and for one clock after the grant falls.
- R6: When the request is sampled low while granted, the grant falls on the next clock and the write inhibit falls one clock after that.
- R7: When the request is withdrawn during the flush phase, the gate returns to idle without granting, and the flush request and write inhibit fall on the next clock.
- R8: The flush request stays high from its rise until the grant rises or the request is withdrawn, and it is never high together with the grant.
- R9: A clock with buffer-empty low during the flush phase restarts the qualifying count from zero.
- R10: With `HAS_MASTER` = 0, all three outputs stay low whatever the inputs do.
- R11: A request seen during the clock in which the write inhibit is still high after a grant has ended is not acted on in that clock. The next flush request rises one clock after the gate has returned to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mst_req_i | input | 1 | Legacy master bus request |
| mst_gnt_o | output | 1 | Legacy bus grant to the master |
| flush_req_o | output | 1 | Out-of-band request to the bridge to drain legacy-bound posted writes |
| buf_empty_i | input | 1 | Bridge indication that its legacy-bound posted-write buffer is empty |
| wr_inhibit_o | output | 1 | Tells the bridge to accept no new legacy-bound posted writes |

## Verification
Directed patterns cover the main cases. A steady empty indication fixes the grant latency, and an empty indication with a one-clock gap shows that the count restarts and is not simply accumulated. A request withdrawn mid-flush separates abort from grant. A request dropped and raised again at once shows the one-clock release step. Long random runs with a sticky request and a flickering empty input compare every output against a bench reference model on each clock. A second instance built without master support, driven by the same inputs, shows that its outputs stay quiet.

// File: rtl/mfg_pkg.sv
package mfg_pkg;
   typedef enum logic [2:0] {
      GS_IDLE  = 3'd0,
      GS_FLUSH = 3'd1,
      GS_WAIT  = 3'd2,
      GS_OWN   = 3'd3,
      GS_DROP  = 3'd4
   } gate_state_t;
endpackage

// File: rtl/empty_qualify.sv
module empty_qualify #(
   parameter int SYNC_STAGES = 0,
   parameter int EMPTY_HOLD  = 1
) (
   input  logic clk,
   input  logic rst,
   input  logic arm_i,
   input  logic empty_i,
   output logic ok_o
);
   localparam int CW = $clog2(EMPTY_HOLD + 1);
   localparam logic [CW-1:0] HOLD_V = CW'(EMPTY_HOLD);

   logic          empty_s;
   logic [CW-1:0] run_q;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign empty_s = empty_i;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sh_q;
         always_ff @(posedge clk) begin
            if (rst) sh_q <= '0;
            else     sh_q <= {sh_q[SYNC_STAGES-2 >= 0 ? SYNC_STAGES-2 : 0 : 0], empty_i};
         end
         assign empty_s = sh_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst || !arm_i || !empty_s) run_q <= '0;
      else if (run_q != HOLD_V)      run_q <= run_q + 1'b1;
   end

   assign ok_o = (run_q == HOLD_V);

   // R9
   empty_gap_chk: assert property (@(posedge clk) disable iff (rst)
      !empty_s |=> !ok_o);
endmodule

// File: rtl/gate_fsm.sv
module gate_fsm
   import mfg_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic req_i,
   input  logic ok_i,
   output logic gnt_o,
   output logic flush_o,
   output logic inh_o
);
   gate_state_t st_q, st_d;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         GS_IDLE:  if (req_i) st_d = GS_FLUSH;
         GS_FLUSH: st_d = req_i ? GS_WAIT : GS_IDLE;
         GS_WAIT:  if (!req_i) st_d = GS_IDLE;
                   else if (ok_i) st_d = GS_OWN;
         GS_OWN:   if (!req_i) st_d = GS_DROP;
         GS_DROP:  st_d = GS_IDLE;
         default:  st_d = GS_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) st_q <= GS_IDLE;
      else     st_q <= st_d;
   end

   assign gnt_o   = (st_q == GS_OWN);
   assign flush_o = (st_q == GS_FLUSH) || (st_q == GS_WAIT);
   assign inh_o   = (st_q != GS_IDLE);

   // R5
   inh_covers_gnt_chk: assert property (@(posedge clk) disable iff (rst)
      gnt_o |-> inh_o);
   // R8
   gnt_flush_excl_chk: assert property (@(posedge clk) disable iff (rst)
      !(gnt_o && flush_o));
   // R3
   gnt_after_ok_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(gnt_o) |-> $past(ok_i));
   // R2
   req_flush_chk: assert property (@(posedge clk) disable iff (rst)
      (!inh_o && req_i) |=> (flush_o && !gnt_o));
   // R6
   drop_gnt_chk: assert property (@(posedge clk) disable iff (rst)
      (gnt_o && !req_i) |=> (!gnt_o && inh_o));
   // R6
   drop_inh_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(gnt_o) |=> !inh_o);
   // R7
   withdraw_chk: assert property (@(posedge clk) disable iff (rst)
      (flush_o && !req_i) |=> (!gnt_o && !flush_o && !inh_o));
endmodule

// File: rtl/master_flush_gate.sv
module master_flush_gate #(
   parameter int HAS_MASTER  = 1,
   parameter int SYNC_STAGES = 0,
   parameter int EMPTY_HOLD  = 1
) (
   input  logic clk,
   input  logic rst,
   input  logic mst_req_i,
   output logic mst_gnt_o,
   output logic flush_req_o,
   input  logic buf_empty_i,
   output logic wr_inhibit_o
);
   localparam logic MASTER_EN = (HAS_MASTER != 0);

   generate
      if (EMPTY_HOLD < 1) begin : g_bad_hold
         $error("EMPTY_HOLD must be at least 1");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 3) begin : g_bad_sync
         $error("SYNC_STAGES must lie in 0..3");
      end
      if (HAS_MASTER != 0 && HAS_MASTER != 1) begin : g_bad_mst
         $error("HAS_MASTER must be 0 or 1");
      end
   endgenerate

   logic req_g;
   logic ok_w;
   logic flush_w;

   assign req_g = mst_req_i & MASTER_EN;

   empty_qualify #(
      .SYNC_STAGES(SYNC_STAGES),
      .EMPTY_HOLD (EMPTY_HOLD)
   ) i_qual (
      .clk    (clk),
      .rst    (rst),
      .arm_i  (flush_w),
      .empty_i(buf_empty_i),
      .ok_o   (ok_w)
   );

   gate_fsm i_fsm (
      .clk    (clk),
      .rst    (rst),
      .req_i  (req_g),
      .ok_i   (ok_w),
      .gnt_o  (mst_gnt_o),
      .flush_o(flush_w),
      .inh_o  (wr_inhibit_o)
   );

   assign flush_req_o = flush_w;
endmodule

// File: tb/test_master_flush_gate.sv
`timescale 1ns/1ps
module test_master_flush_gate;
   localparam int HOLD = 3;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic rst, req, emp;
   logic gnt, flush, inh;
   logic gnt_t, flush_t, inh_t;

   int errs = 0, checks = 0;
   bit done = 0;
   int ms = 0, mcnt = 0;

   master_flush_gate #(.HAS_MASTER(1), .SYNC_STAGES(0), .EMPTY_HOLD(HOLD)) i_master_flush_gate (
      .clk(clk), .rst(rst), .mst_req_i(req), .mst_gnt_o(gnt),
      .flush_req_o(flush), .buf_empty_i(emp), .wr_inhibit_o(inh));

   master_flush_gate #(.HAS_MASTER(0), .SYNC_STAGES(0), .EMPTY_HOLD(HOLD)) i_master_flush_gate_tgt (
      .clk(clk), .rst(rst), .mst_req_i(req), .mst_gnt_o(gnt_t),
      .flush_req_o(flush_t), .buf_empty_i(emp), .wr_inhibit_o(inh_t));

   task automatic check(input string tag, input logic got, input logic exp);
      checks++;
      if (got !== exp) begin
         errs++;
         $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
      end
   endtask

   // reference model, states 0 idle,1 flush,2 wait,3 granted,4 release
   function automatic int nxt_state(int s, logic r, bit ok);
      case (s)
         0: return r ? 1 : 0;
         1: return r ? 2 : 0;
         2: return !r ? 0 : (ok ? 3 : 2);
         3: return r ? 3 : 4;
         default: return 0;
      endcase
   endfunction

   function automatic int nxt_cnt(int s, int c, logic e);
      if (!(s == 1 || s == 2) || !e) return 0;
      return (c < HOLD) ? c + 1 : c;
   endfunction

   task automatic cyc(input logic r, input logic e);
      int s0, c0;
      req = r; emp = e;
      @(posedge clk);
      s0 = ms; c0 = mcnt;
      ms   = nxt_state(s0, r, (c0 == HOLD));
      mcnt = nxt_cnt(s0, c0, e);
      @(negedge clk);
      check("R3 grant",    gnt,   ms == 3);
      check("R8 flush",    flush, ms == 1 || ms == 2);
      check("R5 inhibit",  inh,   ms != 0);
      check("R10 nomaster", gnt_t | flush_t | inh_t, 1'b0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errs++; checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin
      int r_sticky;
      rst = 1'b1; req = 1'b0; emp = 1'b0;
      void'($urandom(32'd4242));
      @(negedge clk); @(negedge clk);
      rst = 1'b0; ms = 0; mcnt = 0;
      @(negedge clk);
      // R1 reset state
      check("R1 grant", gnt, 1'b0);
      check("R1 flush", flush, 1'b0);
      check("R1 inhibit", inh, 1'b0);

      // R2 / R3: steady empty, grant after HOLD+2 clocks
      cyc(1, 1);
      check("R2 flush", flush, 1'b1);
      check("R2 inhibit", inh, 1'b1);
      check("R2 grant", gnt, 1'b0);
      cyc(1, 1); cyc(1, 1); cyc(1, 1);
      check("R3 early grant", gnt, 1'b0);
      cyc(1, 1);
      check("R3 grant", gnt, 1'b1);
      check("R8 flush dropped", flush, 1'b0);
      cyc(1, 0);
      // R6 release order
      cyc(0, 0);
      check("R6 grant off", gnt, 1'b0);
      check("R6 inhibit held", inh, 1'b1);
      cyc(0, 0);
      check("R6 inhibit off", inh, 1'b0);

      // R4: empty never high
      for (int i = 0; i < 20; i++) cyc(1, 0);
      check("R4 no grant", gnt, 1'b0);
      check("R4 flush held", flush, 1'b1);
      // R7 withdrawal in wait
      cyc(0, 1);
      check("R7 grant", gnt, 1'b0);
      check("R7 flush", flush, 1'b0);
      check("R7 inhibit", inh, 1'b0);

      // R9: gap restarts count
      cyc(1, 1); cyc(1, 1); cyc(1, 1); cyc(1, 0);
      cyc(1, 1); cyc(1, 1); cyc(1, 1);
      check("R9 no grant yet", gnt, 1'b0);
      cyc(1, 1);
      check("R9 grant", gnt, 1'b1);

      // R11: request during release clock not acted on
      cyc(0, 1);
      check("R11 release inhibit", inh, 1'b1);
      cyc(1, 1);
      check("R11 flush idle", flush, 1'b0);
      check("R11 inhibit idle", inh, 1'b0);
      cyc(1, 1);
      check("R11 flush restarts", flush, 1'b1);
      cyc(0, 0);

      // random traffic against the model
      r_sticky = 0;
      for (int i = 0; i < 4000; i++) begin
         if (($urandom % 8) == 0) r_sticky = !r_sticky;
         cyc(logic'(r_sticky), logic'(($urandom % 10) < 6));
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule